// File: doc/BRIEF.md
# Two-Phase DRAM Command Decoder

This block sits on the device side of a DDR5-style command/address interface. Each clock it looks at an active-low chip select and a 14-bit command/address bus. It decides whether a new command takes one clock or two, and collects the second half when two are needed. Once the command is complete, it applies the acceptance rules and emits one registered result. That result is either a single-clock `cmd_valid` strobe with decoded fields, or a single-clock `cmd_err` strobe.

For some two-clock commands, the chip select level in the second clock asks the device to drive termination on behalf of another rank. For others, the same level cancels the command. A control-word bit can drop a mode-register write, and three configuration inputs shape the result. Those inputs stand for mode-register state: the alternate burst setting, the refresh-rate report enable, and the refresh-management requirement. The opcode encodings are placeholders chosen for this block and are listed in the requirements.

Top module: `dram_cmd_decoder`

## Requirements
- R1: A command starts only in idle when `cs_n` is 0. If `ca[1]`=1 it is a one-clock command, and its result appears after the capture edge. If `ca[1]`=0 the next clock is always its second half, and its result appears after that second edge. `ca[11:0]` in that clock are opcode or field bits only; no field comes from second-clock `ca[13:12]`.
- R2: With `cs_n`=1 in idle nothing is reported. During the second clock of a command, `cs_n`=0 never starts a new command, and the clock after a two-clock result is quiet while `cs_n`=1.
- R3: Two-clock opcodes: `ca[0]`=0 is ACT. `ca[0]`=1 decodes `ca[4:2]`: 0 WR, 1 RD, 2 MRW, 3 MRR, 4 WRP, 5 BO, and 6 or 7 give `cmd_err`. One-clock opcodes on `ca[4:2]`: 0 REFA, 1 REFSB, 2 PREA, 3 PRESB, 4 PRE, 5 NOP (no result), and 6 or 7 give `cmd_err`. `cmd_type` codes: ACT 1, WR 2, RD 3, MRW 4, MRR 5, WRP 6, BO 7, REFA 8, REFSB 9, PREA 10, PRESB 11, PRE 12.
- R4: For WR, RD and MRR, `cs_n`=0 in the second clock leaves the command valid and sets `nt_odt`. Every other result has `nt_odt`=0.
- R5: For ACT, MRW and WRP, `cs_n`=0 in the second clock cancels the command: `cmd_valid`=0 and `cmd_err`=1.
- R6: A non-cancelled MRW with control-word bit `ca[11]`=1 is silently dropped, so neither strobe fires. MRR is valid for either value of `ca[11]`.
- R7: ACT, WR, RD, WRP and PRE report `bg`=`ca[10:8]` and `ba`=`ca[7:6]` from the first clock. REFSB and PRESB report `ba`=`ca[7:6]` and `bg`=0. All other results report `bg`=`ba`=0.
- R8: WR and RD report `burst_sel`=0 (length 16) when `ca[5]`=1, and `burst_sel`=`cfg_burst` when `ca[5]`=0. Other types report 0, except WRP.
- R9: WRP is valid only when `cfg_burst` is 0 (length 16) or 2 (length 32), and it reports `burst_sel`=`cfg_burst`. Any other setting gives `cmd_err`.
- R10: On REFA and REFSB, `rate_2x`=1 exactly when `cfg_rate_en`=1 and `ca[8]`=0. It is 0 otherwise and on all other types.
- R11: On REFA and REFSB, `rfm`=`ca[9]` when `cfg_rfm_req`=1. It is 0 when `cfg_rfm_req`=0 and on all other types.
- R12: BO is valid only when second-clock `ca[1:0]` are both 0. Otherwise it gives `cmd_err`.
- R13: `cmd_valid` and `cmd_err` never assert together. While `rst_n` is low all outputs are 0 and the decoder is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| ca | input | 14 | Command/address bus |
| cfg_burst | input | 2 | Alternate burst setting (0 length 16, 2 length 32, others other modes) |
| cfg_rate_en | input | 1 | Refresh-rate report enable |
| cfg_rfm_req | input | 1 | Refresh management required |
| cmd_valid | output | 1 | One-clock decoded-command strobe |
| cmd_err | output | 1 | One-clock malformed or cancelled command strobe |
| cmd_type | output | 4 | Command type code |
| bg | output | 3 | Bank group |
| ba | output | 2 | Bank |
| burst_sel | output | 2 | Selected burst mode |
| nt_odt | output | 1 | Non-target termination request |
| rate_2x | output | 1 | Refresh issued at the doubled rate |
| rfm | output | 1 | Refresh-management flag |

## Verification
On every cycle the assertions check these properties:
- the two strobes stay exclusive;
- `nt_odt` appears only on WR, RD or MRR;
- an ACT, MRW or WRP result never follows a low second-clock select;
- WRP bursts stay within the two legal settings;
- all-bank and same-bank commands report a zero bank group;
- the refresh flags appear only when their configuration was set;
- two two-clock results never arrive back to back.

The bench's sweeps are needed for the exact opcode map, the field values, and the burst selection. They are also the only way to show the silent MRW drop, the BO second-clock rule, and the timing of results after each edge.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam int CA_W  = 14;
  localparam int BG_W  = 3;
  localparam int BA_W  = 2;
  localparam int BL_W  = 2;
  localparam int OP_LO = 2;
  localparam int OP_HI = 4;
  localparam int BA_LO = 6;
  localparam int BG_LO = 8;
  localparam int BLB   = 5;
  localparam int RATEB = 8;
  localparam int RFMB  = 9;
  localparam int CWB   = 11;

  localparam logic [BL_W-1:0] BURST_16 = 2'd0;
  localparam logic [BL_W-1:0] BURST_32 = 2'd2;

  typedef enum logic [3:0] {
    T_NONE  = 4'd0,
    T_ACT   = 4'd1,
    T_WR    = 4'd2,
    T_RD    = 4'd3,
    T_MRW   = 4'd4,
    T_MRR   = 4'd5,
    T_WRP   = 4'd6,
    T_BO    = 4'd7,
    T_REFA  = 4'd8,
    T_REFSB = 4'd9,
    T_PREA  = 4'd10,
    T_PRESB = 4'd11,
    T_PRE   = 4'd12
  } ctype_e;

  typedef struct packed {
    logic              valid;
    logic              err;
    ctype_e            ctype;
    logic [BG_W-1:0]   bg;
    logic [BA_W-1:0]   ba;
    logic [BL_W-1:0]   burst;
    logic              nt_odt;
    logic              rate_2x;
    logic              rfm;
  } dec_out_t;
endpackage

// File: rtl/dcd_framer.sv
module dcd_framer
  import dcd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic [CA_W-1:0] ca,
  output logic            wait_q,
  output logic [CA_W-1:0] hold_q
);
  logic            wait_d;
  logic            cap_en;
  logic [CA_W-1:0] hold_d;

  always_comb begin
    cap_en = !wait_q && !cs_n && !ca[1];
    wait_d = cap_en;
    hold_d = cap_en ? ca : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= 1'b0;
      hold_q <= '0;
    end else begin
      wait_q <= wait_d;
      if (cap_en) hold_q <= hold_d;
    end
  end
endmodule

// File: rtl/dcd_decode.sv
module dcd_decode
  import dcd_pkg::*;
(
  input  logic            wait_q,
  input  logic [CA_W-1:0] hold_q,
  input  logic            cs_n,
  input  logic [CA_W-1:0] ca,
  input  logic [BL_W-1:0] cfg_burst,
  input  logic            cfg_rate_en,
  input  logic            cfg_rfm_req,
  output dec_out_t        nxt
);
  logic [OP_HI-OP_LO:0] op1;
  logic [OP_HI-OP_LO:0] op2;
  logic                 wrp_ok;

  assign op1    = ca[OP_HI:OP_LO];
  assign op2    = hold_q[OP_HI:OP_LO];
  assign wrp_ok = (cfg_burst == BURST_16) || (cfg_burst == BURST_32);

  always_comb begin
    nxt = '0;
    if (wait_q) begin
      // second half of a two-clock command
      if (!hold_q[0]) begin
        if (cs_n) begin
          nxt.valid = 1'b1;
          nxt.ctype = T_ACT;
          nxt.bg    = hold_q[BG_LO +: BG_W];
          nxt.ba    = hold_q[BA_LO +: BA_W];
        end else begin
          nxt.err = 1'b1;
        end
      end else begin
        case (op2)
          3'd0, 3'd1: begin
            nxt.valid  = 1'b1;
            nxt.ctype  = (op2 == 3'd0) ? T_WR : T_RD;
            nxt.bg     = hold_q[BG_LO +: BG_W];
            nxt.ba     = hold_q[BA_LO +: BA_W];
            nxt.burst  = hold_q[BLB] ? BURST_16 : cfg_burst;
            nxt.nt_odt = !cs_n;
          end
          3'd2: begin
            if (!cs_n) begin
              nxt.err = 1'b1;
            end else if (!hold_q[CWB]) begin
              nxt.valid = 1'b1;
              nxt.ctype = T_MRW;
            end
          end
          3'd3: begin
            nxt.valid  = 1'b1;
            nxt.ctype  = T_MRR;
            nxt.nt_odt = !cs_n;
          end
          3'd4: begin
            if (!cs_n || !wrp_ok) begin
              nxt.err = 1'b1;
            end else begin
              nxt.valid = 1'b1;
              nxt.ctype = T_WRP;
              nxt.bg    = hold_q[BG_LO +: BG_W];
              nxt.ba    = hold_q[BA_LO +: BA_W];
              nxt.burst = cfg_burst;
            end
          end
          3'd5: begin
            if (ca[1:0] != 2'b00) begin
              nxt.err = 1'b1;
            end else begin
              nxt.valid = 1'b1;
              nxt.ctype = T_BO;
            end
          end
          default: nxt.err = 1'b1;
        endcase
      end
    end else if (!cs_n && ca[1]) begin
      // one-clock command
      case (op1)
        3'd0, 3'd1: begin
          nxt.valid   = 1'b1;
          nxt.ctype   = (op1 == 3'd0) ? T_REFA : T_REFSB;
          nxt.ba      = (op1 == 3'd1) ? ca[BA_LO +: BA_W] : '0;
          nxt.rate_2x = cfg_rate_en && !ca[RATEB];
          nxt.rfm     = cfg_rfm_req && ca[RFMB];
        end
        3'd2: begin
          nxt.valid = 1'b1;
          nxt.ctype = T_PREA;
        end
        3'd3: begin
          nxt.valid = 1'b1;
          nxt.ctype = T_PRESB;
          nxt.ba    = ca[BA_LO +: BA_W];
        end
        3'd4: begin
          nxt.valid = 1'b1;
          nxt.ctype = T_PRE;
          nxt.bg    = ca[BG_LO +: BG_W];
          nxt.ba    = ca[BA_LO +: BA_W];
        end
        3'd5:    nxt = '0;
        default: nxt.err = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/dcd_outreg.sv
module dcd_outreg
  import dcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  dec_out_t nxt,
  output dec_out_t cur
);
  logic upd_en;
  assign upd_en = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else if (upd_en) cur <= nxt;
  end
endmodule

// File: rtl/dram_cmd_decoder.sv
module dram_cmd_decoder
  import dcd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic [CA_W-1:0] ca,
  input  logic [BL_W-1:0] cfg_burst,
  input  logic            cfg_rate_en,
  input  logic            cfg_rfm_req,
  output logic            cmd_valid,
  output logic            cmd_err,
  output logic [3:0]      cmd_type,
  output logic [BG_W-1:0] bg,
  output logic [BA_W-1:0] ba,
  output logic [BL_W-1:0] burst_sel,
  output logic            nt_odt,
  output logic            rate_2x,
  output logic            rfm
);
  logic            wait_q;
  logic [CA_W-1:0] hold_q;
  dec_out_t        nxt;
  dec_out_t        cur;

  dcd_framer i_framer (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ca(ca),
    .wait_q(wait_q), .hold_q(hold_q)
  );

  dcd_decode i_decode (
    .wait_q(wait_q), .hold_q(hold_q), .cs_n(cs_n), .ca(ca),
    .cfg_burst(cfg_burst), .cfg_rate_en(cfg_rate_en),
    .cfg_rfm_req(cfg_rfm_req), .nxt(nxt)
  );

  dcd_outreg i_outreg (
    .clk(clk), .rst_n(rst_n), .nxt(nxt), .cur(cur)
  );

  assign cmd_valid = cur.valid;
  assign cmd_err   = cur.err;
  assign cmd_type  = cur.ctype;
  assign bg        = cur.bg;
  assign ba        = cur.ba;
  assign burst_sel = cur.burst;
  assign nt_odt    = cur.nt_odt;
  assign rate_2x   = cur.rate_2x;
  assign rfm       = cur.rfm;
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker
  import dcd_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic [BL_W-1:0] cfg_burst,
  input logic            cfg_rate_en,
  input logic            cfg_rfm_req,
  input logic            cmd_valid,
  input logic            cmd_err,
  input logic [3:0]      cmd_type,
  input logic [BG_W-1:0] bg,
  input logic [BL_W-1:0] burst_sel,
  input logic            nt_odt,
  input logic            rate_2x,
  input logic            rfm
);
  logic two_clk;
  assign two_clk = cmd_valid && (cmd_type >= 4'd1) && (cmd_type <= 4'd7);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_err)); // R13

  AST_ODT_TYPES: assert property (@(posedge clk) disable iff (!rst_n)
    nt_odt |-> cmd_valid && (cmd_type == T_WR || cmd_type == T_RD || cmd_type == T_MRR)); // R4

  AST_CANCEL_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_type == T_ACT || cmd_type == T_MRW || cmd_type == T_WRP)
      |-> $past(cs_n)); // R5

  AST_WRP_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_type == T_WRP |-> (burst_sel == BURST_16 || burst_sel == BURST_32)); // R9

  AST_WIDE_BG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_type == T_REFA || cmd_type == T_REFSB ||
                  cmd_type == T_PREA || cmd_type == T_PRESB) |-> bg == '0); // R7

  AST_RATE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rate_2x |-> $past(cfg_rate_en)); // R10

  AST_RFM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    rfm |-> $past(cfg_rfm_req)); // R11

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    two_clk |=> !two_clk); // R2
endmodule

bind dram_cmd_decoder dcd_checker i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cfg_burst(cfg_burst),
  .cfg_rate_en(cfg_rate_en), .cfg_rfm_req(cfg_rfm_req),
  .cmd_valid(cmd_valid), .cmd_err(cmd_err), .cmd_type(cmd_type),
  .bg(bg), .burst_sel(burst_sel), .nt_odt(nt_odt),
  .rate_2x(rate_2x), .rfm(rfm)
);

// File: tb/test_dram_cmd_decoder.sv
module test_dram_cmd_decoder;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n;
  logic [13:0] ca;
  logic [1:0]  cfg_burst;
  logic        cfg_rate_en;
  logic        cfg_rfm_req;
  logic        cmd_valid, cmd_err, nt_odt, rate_2x, rfm;
  logic [3:0]  cmd_type;
  logic [2:0]  bg;
  logic [1:0]  ba, burst_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(PERIOD/2) clk = ~clk;

  dram_cmd_decoder i_dram_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ca(ca),
    .cfg_burst(cfg_burst), .cfg_rate_en(cfg_rate_en), .cfg_rfm_req(cfg_rfm_req),
    .cmd_valid(cmd_valid), .cmd_err(cmd_err), .cmd_type(cmd_type),
    .bg(bg), .ba(ba), .burst_sel(burst_sel), .nt_odt(nt_odt),
    .rate_2x(rate_2x), .rfm(rfm)
  );

  // expected result, computed from the requirement text
  logic       e_v, e_e, e_odt, e_r2, e_rfm;
  logic [3:0] e_t;
  logic [2:0] e_bg;
  logic [1:0] e_ba, e_bl;

  function automatic void clr();
    e_v = 0; e_e = 0; e_odt = 0; e_r2 = 0; e_rfm = 0;
    e_t = 0; e_bg = 0; e_ba = 0; e_bl = 0;
  endfunction

  task automatic check(input string req);
    bit bad;
    n_chk++;
    bad = (cmd_valid !== e_v) || (cmd_err !== e_e);
    if (e_v)
      bad = bad || (cmd_type !== e_t) || (bg !== e_bg) || (ba !== e_ba) ||
            (burst_sel !== e_bl) || (nt_odt !== e_odt) || (rate_2x !== e_r2) ||
            (rfm !== e_rfm);
    if (bad) begin
      n_bad++;
      $display("FAIL %s: got v=%0b e=%0b t=%0d bg=%0d ba=%0d bl=%0d odt=%0b r2=%0b rfm=%0b exp v=%0b e=%0b t=%0d bg=%0d ba=%0d bl=%0d odt=%0b r2=%0b rfm=%0b",
               req, cmd_valid, cmd_err, cmd_type, bg, ba, burst_sel, nt_odt, rate_2x, rfm,
               e_v, e_e, e_t, e_bg, e_ba, e_bl, e_odt, e_r2, e_rfm);
    end
  endtask

  task automatic quiet(input string req);
    clr();
    check(req);
  endtask

  // one-clock command
  task automatic one(input logic [13:0] c);
    int op;
    @(negedge clk);
    cs_n = 0; ca = c;
    @(negedge clk);
    cs_n = 1; ca = ~c;
    clr();
    op = c[4:2];
    if (op == 0 || op == 1) begin
      e_v = 1; e_t = (op == 0) ? 4'd8 : 4'd9;
      if (op == 1) e_ba = c[7:6];
      e_r2  = cfg_rate_en & ~c[8];
      e_rfm = cfg_rfm_req & c[9];
    end else if (op == 2) begin e_v = 1; e_t = 4'd10; end
    else if (op == 3) begin e_v = 1; e_t = 4'd11; e_ba = c[7:6]; end
    else if (op == 4) begin e_v = 1; e_t = 4'd12; e_bg = c[10:8]; e_ba = c[7:6]; end
    else if (op >= 6) e_e = 1;
    if (op <= 1) check("R10 R11 one-clock refresh");
    else if (op == 5) check("R3 NOP");
    else check("R1 R3 R7 one-clock");
  endtask

  // two-clock command
  task automatic two(input logic [13:0] c1, input logic s2, input logic [13:0] c2);
    int op;
    string req;
    @(negedge clk);
    cs_n = 0; ca = c1;
    @(negedge clk);
    cs_n = s2; ca = c2;
    @(negedge clk);
    cs_n = 1; ca = c2;
    clr();
    op = c1[4:2];
    req = "R1 R3";
    if (!c1[0]) begin
      req = "R5 R7 ACT";
      if (s2) begin e_v = 1; e_t = 1; e_bg = c1[10:8]; e_ba = c1[7:6]; end
      else e_e = 1;
    end else if (op <= 1) begin
      req = "R4 R8 WR/RD";
      e_v = 1; e_t = (op == 0) ? 4'd2 : 4'd3;
      e_bg = c1[10:8]; e_ba = c1[7:6];
      e_bl = c1[5] ? 2'd0 : cfg_burst;
      e_odt = ~s2;
    end else if (op == 2) begin
      req = "R5 R6 MRW";
      if (!s2) e_e = 1;
      else if (!c1[11]) begin e_v = 1; e_t = 4; end
    end else if (op == 3) begin
      req = "R4 R6 MRR";
      e_v = 1; e_t = 5; e_odt = ~s2;
    end else if (op == 4) begin
      req = "R5 R9 WRP";
      if (!s2 || (cfg_burst != 0 && cfg_burst != 2)) e_e = 1;
      else begin e_v = 1; e_t = 6; e_bg = c1[10:8]; e_ba = c1[7:6]; e_bl = cfg_burst; end
    end else if (op == 5) begin
      req = "R12 BO";
      if (c2[1:0] != 0) e_e = 1;
      else begin e_v = 1; e_t = 7; end
    end else e_e = 1;
    check(req);
    @(negedge clk);
    quiet("R2 quiet after two-clock");
  endtask

  initial begin
    rst_n = 0; cs_n = 0; ca = 14'h0002;
    cfg_burst = 0; cfg_rate_en = 0; cfg_rfm_req = 0;
    repeat (3) @(negedge clk);
    quiet("R13 reset");
    @(negedge clk);
    quiet("R13 reset hold");
    cs_n = 1;
    rst_n = 1;
    @(negedge clk);
    quiet("R13 after release");

    // idle with select high
    for (int i = 0; i < 16; i++) begin
      ca = 14'(i * 1117);
      @(negedge clk);
      quiet("R2 idle");
    end

    // one-clock sweep
    for (int cfg = 0; cfg < 4; cfg++) begin
      cfg_rate_en = cfg[0]; cfg_rfm_req = cfg[1];
      for (int op = 0; op < 8; op++)
        for (int f = 0; f < 32; f++)
          one(14'((((f * 7) & 31) << 6) | (op << 2) | 2 | (f & 1)));
    end

    // two-clock sweep
    for (int bl = 0; bl < 4; bl++) begin
      cfg_burst = 2'(bl);
      for (int op = 0; op < 9; op++)
        for (int s2 = 0; s2 < 2; s2++)
          for (int v = 0; v < 8; v++) begin
            logic [13:0] c1, c2;
            c1 = 14'(((v * 5 + op) & 7) << 8) | 14'((v & 3) << 6) |
                 14'((v & 1) << 5) | 14'(((v >> 1) & 1) << 11);
            if (op < 8) c1 = c1 | 14'(op << 2) | 14'd1;
            c2 = 14'((v * 3) & 3) | 14'(v << 9);
            if (op == 0 && v == 0) c2 = 14'h0003; // second-clock looks like a one-clock start
            two(c1, s2[0], c2);
          end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: got hung run, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule